// File: doc/BRIEF.md
# Miss Status Holding Register File

This block sits beside a lockup-free data cache that serves an in-order pipeline. It keeps a small set of entries, and each entry stands for one cache line being fetched from memory. When a load misses, the line address is looked up among the entries that are still waiting for memory. If the line is not there, a free entry is claimed and a single line request goes out to memory in that same cycle. If the line is already being fetched, the load joins that entry. In both cases the load's destination register is recorded against the word it wants, and the pipeline moves on without stalling.

A per-register full/empty scoreboard records which registers still wait for data. Decode presents two source register numbers and is told to hold only if one of them is still empty. Memory returns a whole line, tagged with the entry index. The entry then hands its waiting words to the register file one per cycle and marks each of those registers full. It frees itself on its last writeback.

Top module: `mshr_file`

## Requirements
- R1: After reset every entry is free, every register is full, and `memreq_valid`, `wb_valid`, `miss_stall` and `query_stall` are all low.
- R2: A miss to a line that no waiting entry holds, while an entry is free, is accepted in the same cycle. In that cycle `memreq_valid` is high, `memreq_line` equals the miss line and `memreq_idx` is the lowest free entry index. The destination register reads empty from the next cycle on.
- R3: A miss to a line held by a waiting entry, whose requested word slot is unused, is accepted with `memreq_valid` low. It is recorded in that entry, and its destination register becomes empty.
- R4: `query_stall` is high in the same cycle whenever `query_reg_a` or `query_reg_b` names an empty register, and low otherwise.
- R5: A fill with `fill_idx` naming a waiting entry makes that entry drain from the next cycle. It drives one writeback per cycle in ascending word order, with `wb_data` equal to word w of `fill_data` (bits w*DATA_W upward). Each written register reads full from the cycle after its writeback.
- R6: An entry is free again from the cycle after its last writeback. A later miss to the same line then issues a new memory request.
- R7: With all four entries busy, a miss to a line not held by a waiting entry raises `miss_stall`, issues no request and records nothing, until an entry frees.
- R8: A merging miss whose word slot already holds a waiting register raises `miss_stall`. It changes neither that slot nor the destination register's full/empty bit.
- R9: An allocating miss and a fill to a different entry in the same cycle both take effect.
- R10: When several filled entries have writebacks left, the lowest entry index is served first.
- R11: A fill whose index names an entry that is not waiting for memory has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_valid | input | 1 | A load miss is presented |
| miss_line | input | LINE_W | Line address of the missing load |
| miss_word | input | clog2(WORDS) | Word within the line |
| miss_dest | input | clog2(NUM_REGS) | Destination register of the load |
| miss_stall | output | 1 | Miss cannot be taken this cycle; hold it |
| memreq_valid | output | 1 | Line request to memory |
| memreq_line | output | LINE_W | Requested line address |
| memreq_idx | output | clog2(ENTRIES) | Entry tag the fill must carry |
| fill_valid | input | 1 | Line data returns |
| fill_idx | input | clog2(ENTRIES) | Entry the returning line belongs to |
| fill_data | input | WORDS*DATA_W | Whole line, word 0 in the low bits |
| wb_valid | output | 1 | Register write this cycle |
| wb_reg | output | clog2(NUM_REGS) | Register being written |
| wb_data | output | DATA_W | Value written |
| query_reg_a | input | clog2(NUM_REGS) | First source register from decode |
| query_reg_b | input | clog2(NUM_REGS) | Second source register from decode |
| query_stall | output | 1 | One of the queried registers is empty |

## Verification
A new-line allocation and a line fill for another entry can land in the same cycle. They meet at the entry storage and at the scoreboard. The bench frees one entry, then in a single cycle presents a fresh miss and a fill for a different waiting entry. It judges the cycle by a request carrying the freed index and by the following cycle's writeback carrying the filled entry's word. The two scoreboard queries in that test show that the new destination went empty while the filled register went full.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    ENT_FREE   = 2'd0,
    ENT_PEND   = 2'd1,
    ENT_FILLED = 2'd2
  } ent_state_e;
endpackage

// File: rtl/mshr_pick.sv
module mshr_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  function automatic logic [IW-1:0] lowest(input logic [N-1:0] v);
    lowest = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) lowest = IW'(i);
  endfunction

  assign any = |req;
  assign idx = lowest(req);
endmodule

// File: rtl/mshr_entry.sv
module mshr_entry
  import mshr_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int WORDS  = 4,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_i,
  input  logic [LINE_W-1:0]       addr_i,
  input  logic                    add_slot_i,
  input  logic [WORD_W-1:0]       word_i,
  input  logic [REG_W-1:0]        reg_i,
  input  logic                    fill_i,
  input  logic [WORDS*DATA_W-1:0] fill_data_i,
  input  logic                    drain_i,
  output logic                    pend_o,
  output logic                    filled_o,
  output logic [LINE_W-1:0]       addr_o,
  output logic [WORDS-1:0]        busy_o,
  output logic                    wb_have_o,
  output logic [REG_W-1:0]        wb_reg_o,
  output logic [DATA_W-1:0]       wb_data_o
);
  ent_state_e              state_q, state_d;
  logic [LINE_W-1:0]       addr_q;
  logic [WORDS-1:0]        busy_q, busy_d;
  logic [REG_W-1:0]        dest_q [WORDS];
  logic [WORDS*DATA_W-1:0] data_q;
  logic [WORD_W-1:0]       head_w;
  logic                    take_fill;

  function automatic logic [WORD_W-1:0] first_word(input logic [WORDS-1:0] v);
    first_word = '0;
    for (int i = WORDS - 1; i >= 0; i--) if (v[i]) first_word = WORD_W'(i);
  endfunction

  assign head_w    = first_word(busy_q);
  assign take_fill = fill_i && (state_q == ENT_PEND);

  always_comb begin
    busy_d = busy_q;
    if (alloc_i)    busy_d = '0;
    if (add_slot_i) busy_d[word_i] = 1'b1;
    if (drain_i)    busy_d[head_w] = 1'b0;
  end

  always_comb begin
    state_d = state_q;
    if (alloc_i)                                     state_d = ENT_PEND;
    else if (take_fill)                              state_d = ENT_FILLED;
    else if (state_q == ENT_FILLED && busy_d == '0)  state_d = ENT_FREE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENT_FREE;
      busy_q  <= '0;
    end else begin
      state_q <= state_d;
      busy_q  <= busy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_i)    addr_q         <= addr_i;
    if (add_slot_i) dest_q[word_i] <= reg_i;
    if (take_fill)  data_q         <= fill_data_i;
  end

  assign pend_o    = (state_q == ENT_PEND);
  assign filled_o  = (state_q == ENT_FILLED);
  assign addr_o    = addr_q;
  assign busy_o    = busy_q;
  assign wb_have_o = filled_o && (busy_q != '0);
  assign wb_reg_o  = dest_q[head_w];
  assign wb_data_o = data_q[head_w*DATA_W +: DATA_W];

  AST_ALLOC_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> state_q == ENT_FREE); // R7
  AST_SLOT_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (add_slot_i && !alloc_i) |-> !busy_q[word_i]); // R8
  AST_DRAIN_ONLY_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    drain_i |-> wb_have_o); // R5
  AST_FREE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (filled_o && drain_i && $countones(busy_q) == 1) |=> state_q == ENT_FREE); // R6
  AST_FILL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_i && state_q == ENT_FREE && !alloc_i) |=> state_q == ENT_FREE); // R11
endmodule

// File: rtl/mshr_scoreboard.sv
module mshr_scoreboard #(
  parameter int NUM_REGS = 32,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_reg,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_reg,
  input  logic [REG_W-1:0] qa,
  input  logic [REG_W-1:0] qb,
  output logic             stall_o
);
  logic [NUM_REGS-1:0] empty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= '0;
    end else begin
      if (clr_en) empty_q[clr_reg] <= 1'b0;
      if (set_en) empty_q[set_reg] <= 1'b1;
    end
  end

  assign stall_o = empty_q[qa] | empty_q[qb];

  AST_SET_MARKS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> empty_q[$past(set_reg)]); // R2
  AST_CLR_MARKS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && set_reg == clr_reg)) |=> !empty_q[$past(clr_reg)]); // R5
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int ENTRIES  = 4,
  parameter int WORDS    = 4,
  parameter int NUM_REGS = 32,
  parameter int LINE_W   = 26,
  parameter int DATA_W   = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int REG_W  = $clog2(NUM_REGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    miss_valid,
  input  logic [LINE_W-1:0]       miss_line,
  input  logic [WORD_W-1:0]       miss_word,
  input  logic [REG_W-1:0]        miss_dest,
  output logic                    miss_stall,
  output logic                    memreq_valid,
  output logic [LINE_W-1:0]       memreq_line,
  output logic [IDX_W-1:0]        memreq_idx,
  input  logic                    fill_valid,
  input  logic [IDX_W-1:0]        fill_idx,
  input  logic [WORDS*DATA_W-1:0] fill_data,
  output logic                    wb_valid,
  output logic [REG_W-1:0]        wb_reg,
  output logic [DATA_W-1:0]       wb_data,
  input  logic [REG_W-1:0]        query_reg_a,
  input  logic [REG_W-1:0]        query_reg_b,
  output logic                    query_stall
);
  logic [ENTRIES-1:0] ent_pend, ent_filled, ent_wb_have;
  logic [ENTRIES-1:0] hit_vec, free_vec, drain_sel;
  logic [LINE_W-1:0]  ent_addr    [ENTRIES];
  logic [WORDS-1:0]   ent_busy    [ENTRIES];
  logic [REG_W-1:0]   ent_wb_reg  [ENTRIES];
  logic [DATA_W-1:0]  ent_wb_data [ENTRIES];

  logic             hit_any, free_any, slot_taken, do_alloc, do_merge;
  logic [IDX_W-1:0] hit_idx, free_idx, drain_idx;

  mshr_pick #(.N(ENTRIES)) u_hit   (.req(hit_vec),     .any(hit_any),  .idx(hit_idx));
  mshr_pick #(.N(ENTRIES)) u_free  (.req(free_vec),    .any(free_any), .idx(free_idx));
  mshr_pick #(.N(ENTRIES)) u_drain (.req(ent_wb_have), .any(wb_valid), .idx(drain_idx));

  assign slot_taken = ent_busy[hit_idx][miss_word];
  assign do_alloc   = miss_valid && !hit_any && free_any;
  assign do_merge   = miss_valid && hit_any && !slot_taken;
  assign miss_stall = miss_valid && !do_alloc && !do_merge;

  assign memreq_valid = do_alloc;
  assign memreq_line  = miss_line;
  assign memreq_idx   = free_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic alloc_here;
    assign hit_vec[g]   = ent_pend[g] && (ent_addr[g] == miss_line);
    assign free_vec[g]  = !ent_pend[g] && !ent_filled[g];
    assign alloc_here   = do_alloc && (free_idx == IDX_W'(g));
    assign drain_sel[g] = wb_valid && (drain_idx == IDX_W'(g));

    mshr_entry #(
      .LINE_W(LINE_W), .WORDS(WORDS), .REG_W(REG_W), .DATA_W(DATA_W)
    ) u_entry (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_i     (alloc_here),
      .addr_i      (miss_line),
      .add_slot_i  (alloc_here || (do_merge && hit_idx == IDX_W'(g))),
      .word_i      (miss_word),
      .reg_i       (miss_dest),
      .fill_i      (fill_valid && fill_idx == IDX_W'(g)),
      .fill_data_i (fill_data),
      .drain_i     (drain_sel[g]),
      .pend_o      (ent_pend[g]),
      .filled_o    (ent_filled[g]),
      .addr_o      (ent_addr[g]),
      .busy_o      (ent_busy[g]),
      .wb_have_o   (ent_wb_have[g]),
      .wb_reg_o    (ent_wb_reg[g]),
      .wb_data_o   (ent_wb_data[g])
    );
  end

  assign wb_reg  = ent_wb_reg[drain_idx];
  assign wb_data = ent_wb_data[drain_idx];

  mshr_scoreboard #(.NUM_REGS(NUM_REGS)) u_sb (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (do_alloc || do_merge),
    .set_reg (miss_dest),
    .clr_en  (wb_valid),
    .clr_reg (wb_reg),
    .qa      (query_reg_a),
    .qb      (query_reg_b),
    .stall_o (query_stall)
  );

  AST_ONE_WB_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drain_sel)); // R5
  AST_REQ_TO_FREE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    memreq_valid |-> (!ent_pend[memreq_idx] && !ent_filled[memreq_idx])); // R7
  AST_REQ_BECOMES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    memreq_valid |=> ent_pend[$past(memreq_idx)]); // R2
  AST_NO_REQ_FOR_HELD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && hit_any) |-> !memreq_valid); // R3
endmodule

// File: tb/mshr_file_bench.sv
`timescale 1ns/1ps
module mshr_file_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         miss_valid = 1'b0;
  logic [25:0]  miss_line = '0;
  logic [1:0]   miss_word = '0;
  logic [4:0]   miss_dest = '0;
  logic         miss_stall;
  logic         memreq_valid;
  logic [25:0]  memreq_line;
  logic [1:0]   memreq_idx;
  logic         fill_valid = 1'b0;
  logic [1:0]   fill_idx = '0;
  logic [127:0] fill_data = '0;
  logic         wb_valid;
  logic [4:0]   wb_reg;
  logic [31:0]  wb_data;
  logic [4:0]   query_reg_a = '0;
  logic [4:0]   query_reg_b = '0;
  logic         query_stall;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mshr_file u_mshr_file (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_line(miss_line), .miss_word(miss_word),
    .miss_dest(miss_dest), .miss_stall(miss_stall),
    .memreq_valid(memreq_valid), .memreq_line(memreq_line), .memreq_idx(memreq_idx),
    .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_data(fill_data),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data),
    .query_reg_a(query_reg_a), .query_reg_b(query_reg_b), .query_stall(query_stall)
  );

  function automatic logic [31:0] word_of(input int tag, input int w);
    return 32'hD000_0000 | (32'(tag) << 8) | 32'(w);
  endfunction

  function automatic logic [127:0] line_of(input int tag);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = word_of(tag, w);
    return l;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle's inputs at the falling edge, settle, return before the rising edge
  task automatic step(input bit mv, input int line, input int w, input int d,
                      input bit fv, input int fi, input int tag,
                      input int qa, input int qb);
    @(negedge clk);
    miss_valid  = mv;
    miss_line   = 26'(line);
    miss_word   = 2'(w);
    miss_dest   = 5'(d);
    fill_valid  = fv;
    fill_idx    = 2'(fi);
    fill_data   = line_of(tag);
    query_reg_a = 5'(qa);
    query_reg_b = 5'(qb);
    #1;
  endtask

  task automatic idle(input int qa, input int qb);
    step(0, 0, 0, 0, 0, 0, 0, qa, qb);
  endtask

  task automatic chk_wb(input string req, input bit v, input int r, input logic [31:0] d);
    chk({req, " wb_valid"}, 32'(wb_valid), 32'(v));
    if (v) begin
      chk({req, " wb_reg"}, 32'(wb_reg), 32'(r));
      chk({req, " wb_data"}, wb_data, d);
    end
  endtask

  task automatic test_reset();
    idle(0, 31);
    chk("R1 memreq_valid", 32'(memreq_valid), 0);
    chk("R1 wb_valid", 32'(wb_valid), 0);
    chk("R1 miss_stall", 32'(miss_stall), 0);
    chk("R1 query_stall", 32'(query_stall), 0);
  endtask

  task automatic test_alloc_merge_fill();
    step(1, 'h100, 1, 5, 0, 0, 0, 5, 5);
    chk("R2 miss_stall", 32'(miss_stall), 0);
    chk("R2 memreq_valid", 32'(memreq_valid), 1);
    chk("R2 memreq_line", 32'(memreq_line), 'h100);
    chk("R2 memreq_idx", 32'(memreq_idx), 0);
    chk("R4 not yet empty", 32'(query_stall), 0);
    step(1, 'h100, 3, 7, 0, 0, 0, 0, 5);
    chk("R3 merge accepted", 32'(miss_stall), 0);
    chk("R3 no new request", 32'(memreq_valid), 0);
    chk("R2 dest empty (via R4 port b)", 32'(query_stall), 1);
    step(1, 'h100, 1, 9, 0, 0, 0, 7, 7);
    chk("R8 occupied slot stalls", 32'(miss_stall), 1);
    chk("R8 no request", 32'(memreq_valid), 0);
    chk("R3 merged dest empty", 32'(query_stall), 1);
    idle(9, 9);
    chk("R8 stalled dest untouched", 32'(query_stall), 0);
    step(0, 0, 0, 0, 1, 0, 1, 5, 0);
    chk_wb("R5 no wb in fill cycle", 0, 0, 0);
    idle(5, 0);
    chk_wb("R5 first word", 1, 5, word_of(1, 1));
    chk("R5 reg waits until written", 32'(query_stall), 1);
    idle(5, 5);
    chk_wb("R5 second word", 1, 7, word_of(1, 3));
    chk("R5 reg full after wb", 32'(query_stall), 0);
    idle(7, 7);
    chk_wb("R6 drained", 0, 0, 0);
    chk("R5 second reg full", 32'(query_stall), 0);
    step(1, 'h100, 0, 5, 0, 0, 0, 0, 0);
    chk("R6 line requested again", 32'(memreq_valid), 1);
    chk("R6 reuses idx 0", 32'(memreq_idx), 0);
  endtask

  task automatic test_capacity();
    step(1, 'h200, 0, 1, 0, 0, 0, 0, 0);
    chk("R2 idx1", 32'(memreq_idx), 1);
    step(1, 'h300, 0, 2, 0, 0, 0, 0, 0);
    chk("R2 idx2", 32'(memreq_idx), 2);
    step(1, 'h400, 0, 3, 0, 0, 0, 0, 0);
    chk("R2 idx3", 32'(memreq_idx), 3);
    step(1, 'h500, 0, 4, 0, 0, 0, 0, 0);
    chk("R7 fifth line stalls", 32'(miss_stall), 1);
    chk("R7 no request", 32'(memreq_valid), 0);
    step(1, 'h500, 0, 4, 1, 1, 2, 4, 4);
    chk("R7 still stalled during fill", 32'(miss_stall), 1);
    chk("R7 dest not marked", 32'(query_stall), 0);
    step(1, 'h500, 0, 4, 0, 0, 0, 0, 0);
    chk("R7 stalled while draining", 32'(miss_stall), 1);
    chk_wb("R5 entry1 word", 1, 1, word_of(2, 0));
    step(1, 'h500, 0, 4, 0, 0, 0, 0, 0);
    chk("R7 accepted after free", 32'(miss_stall), 0);
    chk("R7 request idx1", 32'(memreq_idx), 1);
    chk("R7 request valid", 32'(memreq_valid), 1);
  endtask

  task automatic test_alloc_with_fill();
    step(0, 0, 0, 0, 1, 2, 3, 0, 0);
    idle(0, 0);
    chk_wb("R5 entry2 word", 1, 2, word_of(3, 0));
    step(1, 'h600, 2, 6, 1, 0, 4, 0, 0);
    chk("R9 alloc taken", 32'(memreq_valid), 1);
    chk("R9 alloc idx2", 32'(memreq_idx), 2);
    idle(6, 6);
    chk_wb("R9 fill honoured", 1, 5, word_of(4, 0));
    chk("R9 new dest empty", 32'(query_stall), 1);
    idle(5, 5);
    chk_wb("R9 drain done", 0, 0, 0);
    chk("R9 filled reg full", 32'(query_stall), 0);
  endtask

  task automatic test_priority();
    step(1, 'h400, 1, 8, 0, 0, 0, 0, 0);
    chk("R3 merge into idx3", 32'(memreq_valid), 0);
    chk("R3 merge accepted", 32'(miss_stall), 0);
    step(0, 0, 0, 0, 1, 3, 5, 0, 0);
    step(0, 0, 0, 0, 1, 1, 6, 0, 0);
    chk_wb("R10 entry3 first word", 1, 3, word_of(5, 0));
    idle(0, 0);
    chk_wb("R10 lower index wins", 1, 4, word_of(6, 0));
    idle(0, 0);
    chk_wb("R10 entry3 resumes", 1, 8, word_of(5, 1));
    idle(0, 0);
    chk_wb("R10 all drained", 0, 0, 0);
  endtask

  task automatic test_stray_fill();
    step(0, 0, 0, 0, 1, 0, 7, 6, 6);
    idle(6, 6);
    chk_wb("R11 stray fill no wb", 0, 0, 0);
    chk("R11 waiting reg still empty", 32'(query_stall), 1);
    step(0, 0, 0, 0, 1, 2, 8, 6, 6);
    idle(6, 6);
    chk_wb("R5 entry2 word2", 1, 6, word_of(8, 2));
    idle(6, 6);
    chk_wb("R6 drained", 0, 0, 0);
    chk("R5 reg6 full", 32'(query_stall), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_alloc_merge_fill();
    test_capacity();
    test_alloc_with_fill();
    test_priority();
    test_stray_fill();
    idle(0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule